// File: doc/BRIEF.md
# SMBus Block-Transfer Configuration Target

This block is the serial configuration port of a clock generator. It watches a two-wire SMBus (SCL and SDA, both oversampled by the system clock), answers on one fixed device address, and holds a bank of byte-wide configuration registers. The registers are presented to the rest of the chip as one flat parallel vector. A small strap input is captured once after reset and can be read back.

Both directions use block framing. A write names a starting index, then a byte count, then the data bytes, which land in consecutive registers. A read first sends the index in a write phase, then issues a repeated start with the read address. The target answers with the value of its read-count register, followed by consecutive register bytes until the host signals the end with a not-acknowledge. SDA is modelled as an open-drain pull-down enable. There is no stream handshake: the register outputs are level signals that change only when a write byte is accepted, so there is no back-pressure to manage.

Top module: `smb_cfg_target`

## Requirements
- R1: An address byte of 0xD2 (7-bit address 0x69, R/W bit 0) or 0xD3 (R/W bit 1) is acknowledged. Any other address byte is not acknowledged, and every later byte up to the next start or stop is also not acknowledged and has no effect on any register.
- R2: A write of start, 0xD2, index N, count X and then data bytes stores data byte k (k < X) at register N+k (8-bit wrap). The index, the count and every data byte are acknowledged.
- R3: Data bytes beyond the count X, including every data byte when X is 0, are acknowledged but stored nowhere.
- R4: A read of start, 0xD2, index N, repeated start, 0xD3 returns the count byte first and then the registers N, N+1, … (index modulo 256). Each following byte is sent only after a host acknowledge. After the host's not-acknowledge the target leaves SDA released.
- R5: Register 8 is the read-count register. It resets to 0x07, is fully writable, and its current value is the first byte of every read.
- R6: Register 7 (vendor/revision) reads 0x01 and register 9 (device identity) reads 0x3B. Writes to either are acknowledged and ignored.
- R7: Register 6 bits [2:0] hold strap_fs as sampled on the first clock after reset ends, and later strap changes do not alter them. Bits [7:3] are writable and reset to 0b00011. Writes do not reach bits [2:0].
- R8: Reset values, with register i on cfg_q[8i+7:8i]: registers 0, 2 and 3 are 0xFF, register 1 is 0xFE, register 4 is 0x0F, register 5 is 0x00, and registers 10 and up are 0x00.
- R9: An index at or above NUM_REGS (16 by default) is reserved. Writes to it are acknowledged and ignored, and reads of it return 0x00.
- R10: The target changes its SDA drive only while SCL is low. A stop condition returns it to idle with SDA released, ready for the next transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | When high, pull SDA low |
| strap_fs | input | FS_W (3) | Frequency-select straps, captured once after reset |
| cfg_q | output | NUM_REGS*8 (128) | All configuration registers, register i at bits [8i+7:8i] |

## Verification
A wrong bit counter or a wrong acknowledge-slot flag shows up in the ninth SCL period of the affected byte: the target pulls SDA when it should release it, or the reverse. This also breaks every acknowledge that follows. A pointer that advances wrongly shows in cfg_q a few system clocks after the faulty data byte, and in the byte order of the next read. A wrong reset value or a lost strap capture is visible on cfg_q before any bus traffic. A sticky hold state shows when the next valid transaction receives no acknowledge.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  // 7-bit bus address; write byte 0xD2, read byte 0xD3
  localparam logic [6:0] DEV_ADDR7 = 7'h69;

  localparam int unsigned IDX_STRAP  = 6;
  localparam int unsigned IDX_VENDOR = 7;
  localparam int unsigned IDX_RDCNT  = 8;
  localparam int unsigned IDX_DEVID  = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_WCNT,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } smb_state_e;

  function automatic logic [7:0] reg_reset_val(int unsigned idx);
    case (idx)
      0, 2, 3:    return 8'hFF;  // output enables
      1:          return 8'hFE;  // enables with spread bit off
      4:          return 8'h0F;  // stop enables set, drive modes clear
      IDX_STRAP:  return 8'h18;  // strap bits filled after reset
      IDX_VENDOR: return 8'h01;
      IDX_RDCNT:  return 8'h07;
      IDX_DEVID:  return 8'h3B;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_ro_mask(int unsigned idx, int unsigned fs_w);
    case (idx)
      IDX_STRAP:              return 8'((1 << fs_w) - 1);
      IDX_VENDOR, IDX_DEVID:  return 8'hFF;
      default:                return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_pin_front.sv
module smb_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe;
  logic [MSB:0] sda_pipe;
  logic         scl_d;
  logic         sda_d;

  // idle bus is high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_s      = scl_pipe[MSB];
  assign sda_s      = sda_pipe[MSB];
  assign scl_rise   = scl_s & ~scl_d;
  assign scl_fall   = ~scl_s & scl_d;
  assign start_seen = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_seen  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_cfg_regfile.sv
module smb_cfg_regfile
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int FS_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FS_W-1:0]       strap_fs,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            rdcnt_q,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][7:0] regs;
  logic                     strap_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_vld <= 1'b0;
    else        strap_vld <= 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RV = reg_reset_val(i);
    localparam logic [7:0] RM = reg_ro_mask(i, FS_W);
    logic hit;
    assign hit = wr_en && (wr_idx == 8'(i));

    if (i == IDX_STRAP) begin : g_strap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          regs[i] <= RV;
        else if (!strap_vld) regs[i][FS_W-1:0] <= strap_fs;
        else if (hit)        regs[i] <= (regs[i] & RM) | (wr_data & ~RM);
      end
    end else if (RM == 8'hFF) begin : g_const
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= RV;
        else        regs[i] <= RV;
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[i] <= RV;
        else if (hit) regs[i] <= (regs[i] & RM) | (wr_data & ~RM);
      end
    end
  end

  assign rd_data = ({24'd0, rd_idx} < NUM_REGS) ? regs[rd_idx[IW-1:0]] : 8'h00;
  assign rdcnt_q = regs[IDX_RDCNT];
  assign cfg_q   = regs;

  // R6: identity bytes never move once out of reset
  a_r6_ids_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[IDX_VENDOR]) && $stable(regs[IDX_DEVID]));

  // R7: captured strap bits stay put after the capture cycle
  a_r7_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_vld && $past(strap_vld)) |-> $stable(regs[IDX_STRAP][FS_W-1:0]));

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_seen,
  input  logic       stop_seen,
  input  logic [7:0] rdcnt_q,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  smb_state_e st;
  logic [3:0] bitcnt;
  logic       ack_slot;
  logic       ack_want;
  logic       cnt_phase;
  logic       sda_oe_q;
  logic [7:0] shreg;
  logic [7:0] ptr;
  logic [7:0] wr_left;
  logic [7:0] nb;
  logic [7:0] tx_byte;
  logic       byte_in;
  logic       host_ack_slot;

  assign nb      = {shreg[6:0], sda_s};
  assign tx_byte = cnt_phase ? rdcnt_q : rd_data;
  assign byte_in = scl_rise && !ack_slot && (bitcnt == 4'd7) &&
                   (st inside {ST_ADDR, ST_INDEX, ST_WCNT, ST_WDATA});
  assign host_ack_slot = ack_slot && (st == ST_RDATA) && !ack_want;

  assign wr_en   = byte_in && (st == ST_WDATA) && (wr_left != 8'd0);
  assign wr_idx  = ptr;
  assign wr_data = nb;
  assign rd_idx  = ptr;
  assign sda_oe  = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= 4'd0;
      ack_slot  <= 1'b0;
      ack_want  <= 1'b0;
      cnt_phase <= 1'b0;
      sda_oe_q  <= 1'b0;
      shreg     <= 8'd0;
      ptr       <= 8'd0;
      wr_left   <= 8'd0;
    end else if (start_seen) begin
      st       <= ST_ADDR;
      bitcnt   <= 4'd0;
      ack_slot <= 1'b0;
      ack_want <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (stop_seen) begin
      st       <= ST_IDLE;
      bitcnt   <= 4'd0;
      ack_slot <= 1'b0;
      ack_want <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (st != ST_IDLE && st != ST_HOLD) begin
      if (scl_rise) begin
        if (host_ack_slot) begin
          if (sda_s)          st        <= ST_HOLD;  // host ends the read
          else if (cnt_phase) cnt_phase <= 1'b0;
          else                ptr       <= ptr + 8'd1;
        end else if (!ack_slot && bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != ST_RDATA) shreg <= nb;
          if (byte_in) begin
            ack_want <= 1'b1;
            case (st)
              ST_ADDR: begin
                if (nb[7:1] == DEV_ADDR7) begin
                  st        <= nb[0] ? ST_RDATA : ST_INDEX;
                  cnt_phase <= 1'b1;
                end else begin
                  st       <= ST_HOLD;
                  ack_want <= 1'b0;
                end
              end
              ST_INDEX: begin
                ptr <= nb;
                st  <= ST_WCNT;
              end
              ST_WCNT: begin
                wr_left <= nb;
                st      <= ST_WDATA;
              end
              default: begin
                if (wr_en) begin
                  ptr     <= ptr + 8'd1;
                  wr_left <= wr_left - 8'd1;
                end
              end
            endcase
          end
        end
      end else if (scl_fall) begin
        if (ack_slot) begin
          ack_slot <= 1'b0;
          ack_want <= 1'b0;
          bitcnt   <= 4'd0;
          sda_oe_q <= (st == ST_RDATA) ? ~tx_byte[7] : 1'b0;
        end else if (bitcnt == 4'd8) begin
          ack_slot <= 1'b1;
          sda_oe_q <= ack_want;
        end else if (st == ST_RDATA && bitcnt != 4'd0) begin
          sda_oe_q <= ~tx_byte[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  // R10: silent whenever no transfer is addressed to this target
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_HOLD) |-> !sda_oe_q);

  // R10: the drive only moves while SCL is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !$past(scl_s));

  // R2: each stored byte advances the register pointer by one
  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(ptr) + 8'd1);

  // R3: each stored byte consumes one unit of the announced count
  a_r3_count_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_left == $past(wr_left) - 8'd1);

  // R1: bit position never passes the acknowledge slot
  a_r1_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter int NUM_REGS    = 16,
  parameter int FS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [FS_W-1:0]       strap_fs,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_seen, stop_seen;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, rdcnt_q;

  smb_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  smb_xfer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .rdcnt_q    (rdcnt_q),
    .rd_data    (rd_data),
    .rd_idx     (rd_idx),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sda_oe     (sda_oe)
  );

  smb_cfg_regfile #(.NUM_REGS(NUM_REGS), .FS_W(FS_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_fs (strap_fs),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rdcnt_q  (rdcnt_q),
    .cfg_q    (cfg_q)
  );

endmodule

// File: tb/tb_smb_cfg_target.sv
module tb_smb_cfg_target;

  localparam int NR = 16;
  localparam int T  = 12;   // quarter SCL period in system clocks

  logic            clk = 1'b0;
  logic            rst_n;
  logic            scl_h, sda_h;
  logic [2:0]      strap;
  logic            sda_oe;
  logic [NR*8-1:0] cfg;
  logic            sda_line;

  always #2 clk = ~clk;   // 250 MHz

  assign sda_line = sda_h & ~sda_oe;

  smb_cfg_target #(.NUM_REGS(NR)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_h),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .strap_fs (strap),
    .cfg_q    (cfg)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf  [32];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rst_val(int i, logic [2:0] s);
    case (i)
      0, 2, 3: return 8'hFF;
      1:       return 8'hFE;
      4:       return 8'h0F;
      6:       return {5'b00011, s};
      7:       return 8'h01;
      8:       return 8'h07;
      9:       return 8'h3B;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(int i);
    if (i >= NR)            return "R9";
    if (i == 7 || i == 9)   return "R6";
    if (i == 6)             return "R7";
    if (i == 8)             return "R5";
    return "R8";
  endfunction

  task automatic model_reset(input logic [2:0] s);
    for (int i = 0; i < 256; i++) model[i] = (i < NR) ? rst_val(i, s) : 8'h00;
  endtask

  task automatic model_write(input logic [7:0] idx, input logic [7:0] d);
    if (int'(idx) >= NR || idx == 8'd7 || idx == 8'd9) return;
    if (idx == 8'd6) model[6] = {d[7:3], model[6][2:0]};
    else             model[idx] = d;
  endtask

  task automatic hwait();
    repeat (T) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; hwait();
    sda_h = 1'b0; hwait();
    scl_h = 1'b0; hwait();
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; hwait();
    scl_h = 1'b1; hwait();
    sda_h = 1'b0; hwait();
    scl_h = 1'b0; hwait();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hwait();
    scl_h = 1'b1; hwait();
    sda_h = 1'b1; hwait();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; hwait();
    scl_h = 1'b1; hwait(); hwait();
    scl_h = 1'b0; hwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1'b1; hwait();
    scl_h = 1'b1; hwait();
    b = sda_line; hwait();
    scl_h = 1'b0; hwait();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int k = 7; k >= 0; k--) send_bit(d[k]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic host_ack);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      recv_bit(b);
      d[k] = b;
    end
    send_bit(~host_ack);
  endtask

  task automatic check_cfg();
    for (int i = 0; i < NR; i++) chk(tag_of(i), 32'(cfg[8*i +: 8]), 32'(model[i]));
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int nd);
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk("R1 write address ack", 32'(a), 1);
    wbyte(idx, a);   chk("R2 index ack", 32'(a), 1);
    wbyte(cnt, a);   chk("R2 count ack", 32'(a), 1);
    for (int k = 0; k < nd; k++) begin
      wbyte(wbuf[k], a);
      if (k < int'(cnt)) begin
        chk("R2 data ack", 32'(a), 1);
        model_write(idx + 8'(k), wbuf[k]);
      end else begin
        chk("R3 extra byte ack", 32'(a), 1);
      end
    end
    bus_stop();
    chk("R10 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic do_read(input logic [7:0] idx, input int nd);
    logic       a;
    logic [7:0] d;
    logic [7:0] j;
    bus_start();
    wbyte(8'hD2, a); chk("R1 write address ack", 32'(a), 1);
    wbyte(idx, a);   chk("R4 index ack", 32'(a), 1);
    bus_rstart();
    wbyte(8'hD3, a); chk("R1 read address ack", 32'(a), 1);
    rbyte(d, 1'b1);  chk("R5 count byte", 32'(d), 32'(model[8]));
    for (int k = 0; k < nd; k++) begin
      rbyte(d, k != nd - 1);
      j = idx + 8'(k);
      chk({"R4 read data ", tag_of(int'(j))}, 32'(d), 32'(model[j]));
    end
    chk("R4 released after nack", 32'(sda_oe), 0);
    bus_stop();
    chk("R10 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic do_reset(input logic [2:0] s);
    strap = s;
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset(s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] keep0, keep1;
    logic [7:0] foreign [4];
    scl_h = 1'b1;
    sda_h = 1'b1;
    do_reset(3'b101);

    // R8 / R7 / R6 / R5: reset image, visible before any traffic
    check_cfg();
    chk("R10 idle after reset", 32'(sda_oe), 0);

    // R7: strap change after capture has no effect
    strap = 3'b010;
    repeat (5) @(negedge clk);
    chk("R7 strap frozen", 32'(cfg[8*6 +: 8]), 32'h1D);

    // R4 / R9: read the whole bank plus two reserved indices
    do_read(8'd0, NR + 2);

    // R2 / R6 / R7 / R9: write a computed pattern everywhere
    for (int k = 0; k < NR + 2; k++) wbuf[k] = 8'(k * 37 + 5);
    do_write(8'd0, 8'(NR + 2), NR + 2);
    check_cfg();
    do_read(8'd0, NR + 2);

    // R5: the count register decides the first read byte
    wbuf[0] = 8'h03;
    do_write(8'd8, 8'd1, 1);
    do_read(8'd5, 4);

    // R3: bytes past the count are acknowledged but not stored
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC; wbuf[3] = 8'hDD;
    do_write(8'd11, 8'd2, 4);
    check_cfg();
    do_read(8'd10, 6);

    // R3: count of zero stores nothing
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(8'd2, 8'd0, 2);
    chk("R3 zero count reg2", 32'(cfg[8*2 +: 8]), 32'(model[2]));
    chk("R3 zero count reg3", 32'(cfg[8*3 +: 8]), 32'(model[3]));

    // R1: foreign addresses are ignored along with their payload
    foreign[0] = 8'hD0; foreign[1] = 8'hD4; foreign[2] = 8'h52; foreign[3] = 8'h53;
    for (int f = 0; f < 4; f++) begin
      keep0 = cfg[7:0];
      keep1 = cfg[15:8];
      bus_start();
      wbyte(foreign[f], a); chk("R1 foreign address nack", 32'(a), 0);
      wbyte(8'h00, a);      chk("R1 foreign index nack", 32'(a), 0);
      wbyte(8'h5A, a);      chk("R1 foreign data nack", 32'(a), 0);
      bus_stop();
      chk("R1 reg0 untouched", 32'(cfg[7:0]), 32'(keep0));
      chk("R1 reg1 untouched", 32'(cfg[15:8]), 32'(keep1));
    end

    // R4 / R9: pointer wraps from 255 to 0
    do_read(8'd254, 4);

    // R10: a fresh transaction after all the above still works
    wbuf[0] = 8'h5C;
    do_write(8'd5, 8'd1, 1);
    chk("R10 write after stop", 32'(cfg[8*5 +: 8]), 32'h5C);

    // R7 / R8: new reset with another strap value
    do_reset(3'b010);
    check_cfg();
    chk("R7 strap recaptured", 32'(cfg[8*6 +: 8]), 32'h1A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule